// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block sits beside a serial shift core and watches the clock (SCL) and data (SDA) lines of a two-wire bus after they pass through an internal synchronizer. When a two-wire mode is selected it recognises start and stop conditions and latches a sticky flag for each. It also keeps a sticky counter-overflow flag, fed by a one-cycle pulse from the neighbouring bit counter. Software clears each flag by pulsing its clear input.

After a start condition, and in one mode also after a counter overflow, the block asks the SCL pad to be held low. The hold stays on until software clears the flag that caused it, which stretches the bus clock while software reacts. A collision output compares the shifter's most significant bit with the sensed SDA level, for use in bus arbitration. In the non-two-wire modes the block can instead flag every SCL edge when an external clock source is selected. The open-drain pads are modelled as active-high drive-low enables.

Top module: `twi_bus_monitor`

## Requirements
- R1: Mode encoding: wire_mode 00 = off, 01 = three-wire, 10 = two-wire, 11 = two-wire with overflow hold. In modes 10 and 11, a start condition sets start_flag. A start condition is a synchronized SDA falling edge while synchronized SCL is high. In modes 00 and 01, with ext_clk_sel = 0, a start condition leaves start_flag at 0.
- R2: In modes 00 and 01, with ext_clk_sel = 1 and strobe_sel = 0, every synchronized SCL edge (rising or falling) sets start_flag. With any other ext_clk_sel and strobe_sel setting, SCL edges leave start_flag at 0. In modes 10 and 11, SCL edges with SDA steady leave start_flag at 0.
- R3: In modes 10 and 11, a stop condition sets stop_flag. A stop condition is a synchronized SDA rising edge while synchronized SCL is high. In modes 00 and 01, stop_flag stays 0.
- R4: In modes 10 and 11, with scl_oe = 1, scl_drive_low is 1 while start_flag is set, even when port_scl = 1. The line is released one cycle after a start_clr pulse.
- R5: In mode 11, a set ovf_flag also holds scl_drive_low at 1 while scl_oe = 1. In mode 10, ovf_flag does not hold SCL.
- R6: A cnt_ovf pulse sets ovf_flag in every mode. A one-cycle pulse on start_clr, stop_clr or ovf_clr clears the matching flag. When a set and a clear of the same flag fall in the same cycle, the set wins.
- R7: In modes 10 and 11, collision is 1 exactly when shift_msb differs from the synchronized SDA level. In modes 00 and 01, collision is 0.
- R8: In modes 10 and 11, sda_drive_low = sda_oe & (~shift_msb | ~port_sda). In modes 00 and 01, sda_drive_low is 0.
- R9: In modes 10 and 11, with start_flag and ovf_flag clear, scl_drive_low = scl_oe & ~port_scl. In modes 00 and 01, scl_drive_low is 0.
- R10: start_irq = start_flag & start_ie and ovf_irq = ovf_flag & ovf_ie. A flag that is already pending raises its interrupt as soon as its enable is set. stop_flag drives no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wire_mode | input | 2 | 00 off, 01 three-wire, 10 two-wire, 11 two-wire with overflow hold |
| ext_clk_sel | input | 1 | External clock source selected |
| strobe_sel | input | 1 | Counter clocked by software strobe instead of pin |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| shift_msb | input | 1 | Bit 7 of the shift register |
| cnt_ovf | input | 1 | One-cycle counter overflow pulse |
| start_clr | input | 1 | Write-one-to-clear strobe for start_flag |
| stop_clr | input | 1 | Write-one-to-clear strobe for stop_flag |
| ovf_clr | input | 1 | Write-one-to-clear strobe for ovf_flag |
| start_ie | input | 1 | Start interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| sda_oe | input | 1 | SDA driver enable |
| scl_oe | input | 1 | SCL driver enable |
| port_sda | input | 1 | Port data bit for SDA |
| port_scl | input | 1 | Port data bit for SCL |
| start_flag | output | 1 | Sticky start (or SCL edge) flag |
| stop_flag | output | 1 | Sticky stop flag |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| start_irq | output | 1 | Start interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| collision | output | 1 | Shifter MSB differs from sensed SDA |
| sda_drive_low | output | 1 | Pull SDA low |
| scl_drive_low | output | 1 | Pull SCL low |

## Verification
The assertions assume that cnt_ovf and the clear strobes come from a single clock domain and are sampled at clock edges. They also assume that wire_mode stays stable across the cycle in which a detected condition reaches its flag. The stimulus changes the mode and the clock selects only while the bus lines are quiet. It waits several cycles after every line change so that the synchronizer and the flag register have settled before any mode change. Every line change is driven on the falling clock edge, one signal at a time, so that each start, stop or SCL edge is an isolated event.

// File: rtl/twi_mon_pkg.sv
package twi_mon_pkg;
    typedef enum logic [1:0] {
        WM_OFF     = 2'b00,
        WM_THREE   = 2'b01,
        WM_TWO     = 2'b10,
        WM_TWO_OVF = 2'b11
    } wire_mode_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic ovf;
    } flags_t;

    function automatic logic is_two_wire(wire_mode_t m);
        return m == WM_TWO || m == WM_TWO_OVF;
    endfunction
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] IDLE = '1;

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = d;
            end else begin : g_rest
                always_comb stage_d[g] = stage_q[g-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= IDLE;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_edge
);
    typedef struct packed {
        logic sda;
        logic scl;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.sda = sda_s;
        prev_d.scl = scl_s;
        start_ev   = prev_q.sda && !sda_s && prev_q.scl && scl_s;
        stop_ev    = !prev_q.sda && sda_s && prev_q.scl && scl_s;
        scl_edge   = prev_q.scl ^ scl_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    // R1
    start_needs_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |-> scl_s && !scl_edge);
endmodule

// File: rtl/twi_flags.sv
module twi_flags
    import twi_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wire_mode_t mode,
    input  logic       ext_clk_sel,
    input  logic       strobe_sel,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       scl_edge,
    input  logic       cnt_ovf,
    input  logic       start_clr,
    input  logic       stop_clr,
    input  logic       ovf_clr,
    output flags_t     flags
);
    flags_t flags_d, flags_q;
    logic   edge_mode, two_wire, start_set, stop_set;

    always_comb begin
        two_wire      = is_two_wire(mode);
        edge_mode     = !two_wire && ext_clk_sel && !strobe_sel;
        start_set     = (two_wire && start_ev) || (edge_mode && scl_edge);
        stop_set      = two_wire && stop_ev;
        flags_d.start = start_set || (flags_q.start && !start_clr);
        flags_d.stop  = stop_set  || (flags_q.stop  && !stop_clr);
        flags_d.ovf   = cnt_ovf   || (flags_q.ovf   && !ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ovf |=> flags_q.ovf);

    // R3
    stop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.stop) |-> $past(two_wire));
endmodule

// File: rtl/twi_bus_monitor.sv
module twi_bus_monitor
    import twi_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] wire_mode,
    input  logic       ext_clk_sel,
    input  logic       strobe_sel,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       shift_msb,
    input  logic       cnt_ovf,
    input  logic       start_clr,
    input  logic       stop_clr,
    input  logic       ovf_clr,
    input  logic       start_ie,
    input  logic       ovf_ie,
    input  logic       sda_oe,
    input  logic       scl_oe,
    input  logic       port_sda,
    input  logic       port_scl,
    output logic       start_flag,
    output logic       stop_flag,
    output logic       ovf_flag,
    output logic       start_irq,
    output logic       ovf_irq,
    output logic       collision,
    output logic       sda_drive_low,
    output logic       scl_drive_low
);
    wire_mode_t mode;
    logic [1:0] lines_s;
    logic       sda_s, scl_s;
    logic       start_ev, stop_ev, scl_edge;
    logic       two_wire, hold;
    flags_t     flags;

    assign mode = wire_mode_t'(wire_mode);

    twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sda_in, scl_in}),
        .q     (lines_s)
    );

    assign sda_s = lines_s[1];
    assign scl_s = lines_s[0];

    twi_cond_detect det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_s    (scl_s),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_edge (scl_edge)
    );

    twi_flags flags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .ext_clk_sel (ext_clk_sel),
        .strobe_sel  (strobe_sel),
        .start_ev    (start_ev),
        .stop_ev     (stop_ev),
        .scl_edge    (scl_edge),
        .cnt_ovf     (cnt_ovf),
        .start_clr   (start_clr),
        .stop_clr    (stop_clr),
        .ovf_clr     (ovf_clr),
        .flags       (flags)
    );

    always_comb begin
        two_wire      = is_two_wire(mode);
        hold          = two_wire && (flags.start || (mode == WM_TWO_OVF && flags.ovf));
        scl_drive_low = two_wire && scl_oe && (!port_scl || hold);
        sda_drive_low = two_wire && sda_oe && (!shift_msb || !port_sda);
        collision     = two_wire && (shift_msb ^ sda_s);
        start_flag    = flags.start;
        stop_flag     = flags.stop;
        ovf_flag      = flags.ovf;
        start_irq     = flags.start && start_ie;
        ovf_irq       = flags.ovf && ovf_ie;
    end

    // R9
    off_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wire_mode[1] == 1'b0 |-> !scl_drive_low && !sda_drive_low && !collision);

    // R4
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wire_mode[1] && scl_oe && start_flag) |-> scl_drive_low);

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wire_mode == 2'b11 && scl_oe && ovf_flag) |-> scl_drive_low);

    // R10
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && start_ie) |-> start_irq);
endmodule

// File: tb/twi_bus_monitor_tb_top.sv
`timescale 1ns/1ps
module twi_bus_monitor_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] wire_mode = 0;
    logic       ext_clk_sel = 0, strobe_sel = 0;
    logic       scl_in = 1, sda_in = 1, shift_msb = 1, cnt_ovf = 0;
    logic       start_clr = 0, stop_clr = 0, ovf_clr = 0;
    logic       start_ie = 0, ovf_ie = 0;
    logic       sda_oe = 0, scl_oe = 0, port_sda = 1, port_scl = 1;
    logic       start_flag, stop_flag, ovf_flag, start_irq, ovf_irq;
    logic       collision, sda_drive_low, scl_drive_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    twi_bus_monitor dut_i (.*);

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        start_clr = 1; stop_clr = 1; ovf_clr = 1;
        @(negedge clk);
        start_clr = 0; stop_clr = 0; ovf_clr = 0;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        chk("R6 reset start_flag", start_flag, 0);
        chk("R6 reset stop_flag", stop_flag, 0);
        chk("R6 reset ovf_flag", ovf_flag, 0);
        chk("R9 reset scl_drive_low", scl_drive_low, 0);

        // R1 R3 R4: start, hold, release, stop per mode
        scl_oe = 1; port_scl = 1;
        for (int wm = 0; wm < 4; wm++) begin
            wire_mode = 2'(wm);
            settle();
            sda_in = 0; settle();
            chk("R1 start sets flag", start_flag, wire_mode[1]);
            chk("R4 start hold", scl_drive_low, wire_mode[1]);
            @(negedge clk) start_clr = 1;
            @(negedge clk) start_clr = 0;
            chk("R4 released after clear", scl_drive_low, 0);
            chk("R1 cleared", start_flag, 0);
            sda_in = 1; settle();
            chk("R3 stop sets flag", stop_flag, wire_mode[1]);
            chk("R1 stop no start", start_flag, 0);
            clear_all();
        end

        // R2: SCL edge flagging sweep
        for (int wm = 0; wm < 3; wm++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                wire_mode = (wm == 2) ? 2'b10 : 2'(wm);
                ext_clk_sel = cfg[1]; strobe_sel = cfg[0];
                clear_all();
                scl_in = 0; settle();
                chk("R2 falling scl edge", start_flag,
                    !wire_mode[1] && ext_clk_sel && !strobe_sel);
                clear_all();
                scl_in = 1; settle();
                chk("R2 rising scl edge", start_flag,
                    !wire_mode[1] && ext_clk_sel && !strobe_sel);
            end
        end
        ext_clk_sel = 0; strobe_sel = 0;
        clear_all();

        // R5 R6: overflow flag and hold
        for (int wm = 0; wm < 4; wm++) begin
            wire_mode = 2'(wm);
            clear_all();
            @(negedge clk) cnt_ovf = 1;
            @(negedge clk) cnt_ovf = 0;
            chk("R6 ovf sets flag", ovf_flag, 1);
            chk("R5 ovf hold", scl_drive_low, wm == 3);
            @(negedge clk) begin cnt_ovf = 1; ovf_clr = 1; end
            @(negedge clk) begin cnt_ovf = 0; ovf_clr = 0; end
            chk("R6 set wins over clear", ovf_flag, 1);
            @(negedge clk) ovf_clr = 1;
            @(negedge clk) ovf_clr = 0;
            chk("R6 ovf cleared", ovf_flag, 0);
            chk("R5 released", scl_drive_low, 0);
        end

        // R9: SCL port drive sweep
        for (int wm = 0; wm < 4; wm++) begin
            for (int v = 0; v < 4; v++) begin
                wire_mode = 2'(wm); scl_oe = v[1]; port_scl = v[0];
                @(negedge clk);
                chk("R9 scl drive", scl_drive_low, wire_mode[1] && v[1] && !v[0]);
            end
        end
        port_scl = 1; scl_oe = 0;

        // R7: collision sweep (SCL low so no conditions)
        scl_in = 0; settle();
        for (int wm = 0; wm < 4; wm++) begin
            for (int v = 0; v < 4; v++) begin
                wire_mode = 2'(wm); shift_msb = v[1]; sda_in = v[0];
                settle();
                chk("R7 collision", collision, wire_mode[1] && (v[1] != v[0]));
            end
        end
        sda_in = 1; settle(); scl_in = 1; settle();

        // R8: SDA drive sweep
        for (int wm = 0; wm < 4; wm++) begin
            for (int v = 0; v < 8; v++) begin
                wire_mode = 2'(wm); sda_oe = v[2]; shift_msb = v[1]; port_sda = v[0];
                @(negedge clk);
                chk("R8 sda drive", sda_drive_low, wire_mode[1] && v[2] && (!v[1] || !v[0]));
            end
        end
        sda_oe = 0; shift_msb = 1; port_sda = 1;

        // R10: pending flag, then enable
        wire_mode = 2'b10;
        clear_all();
        sda_in = 0; settle();
        chk("R10 no irq without enable", start_irq, 0);
        @(negedge clk) start_ie = 1;
        #1 chk("R10 pending start fires", start_irq, 1);
        @(negedge clk) cnt_ovf = 1;
        @(negedge clk) cnt_ovf = 0;
        chk("R10 ovf irq masked", ovf_irq, 0);
        ovf_ie = 1; #1;
        chk("R10 ovf irq enabled", ovf_irq, 1);
        clear_all();
        sda_in = 1; settle();
        chk("R10 stop flag set", stop_flag, 1);
        chk("R10 stop raises no start irq", start_irq, 0);
        chk("R10 stop raises no ovf irq", ovf_irq, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule